// File: doc/BRIEF.md
# Double-Buffered Serial Converter Code Receiver

This block is the digital receive side of one serial-loaded converter channel. It runs in a fast system clock domain. It accepts four asynchronous lines: a serial clock, an active-low frame sync, a serial data line and an active-low load strobe. A falling edge on the frame sync opens a frame. The next sixteen falling edges of the serial clock shift sixteen bits into an input register.

The low fourteen bits of that register form the converter code, sent most significant bit first. The two leading bits of each frame carry no meaning. A separate output register holds the code that actually drives the converter, and only that register reaches the output pins.

The output register is loaded in one of two ways. The first is a load-strobe falling edge while no frame is being received. The second is the sixteenth serial clock edge of a frame, provided the strobe is low at that moment. A strobe edge that lands inside a frame is suppressed. Every load of the output register raises a one-cycle update pulse. A registered flag reports that a frame has been fully received. A second channel is simply another instance of this block.

Top module: `dac_serial_port`

## Requirements
- R1: After a synchronous active-low reset, `code_out` is zero, `update_pulse` is low and `frame_done` is low.
- R2: Each bit is taken from `sdata_in` at a falling edge of `sclk_in` inside a frame, shifting into bit 0 of the 16-bit input register. The first two bits of a frame are discarded. The last fourteen bits become the code, first-received bit as code bit 13.
- R3: When no frame is partly received, a falling edge of `load_n_in` copies bits 13..0 of the input register to `code_out` and raises `update_pulse`.
- R4: If `load_n_in` is low at the sixteenth serial clock falling edge of a frame, `code_out` takes the new frame's code at that edge, with one `update_pulse`.
- R5: A `load_n_in` falling edge while a frame is partly received causes no update by itself. If the strobe stays low until the frame completes, the update occurs at the sixteenth edge.
- R6: If `load_n_in` falls mid-frame and rises again before the sixteenth edge, no update results from that strobe event.
- R7: Serial clock falling edges after the sixteenth, while the frame sync stays low, shift nothing. The input register keeps the sixteen captured bits.
- R8: Shifting bits into the input register never changes `code_out` without an update event.
- R9: A frame sync that returns high before sixteen bits have arrived abandons the frame. No update occurs at its end and `frame_done` stays low.
- R10: Every frame sync falling edge restarts the bit count, so a full frame after an abandoned one is captured correctly.
- R11: `frame_done` rises once sixteen bits of a frame are captured. It stays high until the next frame sync falling edge.
- R12: `update_pulse` is exactly one system clock cycle wide for each output update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_in | input | 1 | Asynchronous serial bit clock; bits are taken on its falling edge |
| fsync_n_in | input | 1 | Asynchronous active-low frame sync |
| sdata_in | input | 1 | Asynchronous serial data line |
| load_n_in | input | 1 | Asynchronous active-low load strobe |
| code_out | output | 14 | Converter code held in the output register |
| update_pulse | output | 1 | One-cycle pulse on each output register load |
| frame_done | output | 1 | High once a complete 16-bit frame is captured |

## Verification
The bench builds the block with its default parameters: a 16-bit frame, a 14-bit code and two synchronizer stages. At those values, every strobe position relative to the frame is reachable in a few hundred cycles per frame. This covers the strobe held low before the frame, a strobe falling at any bit, and a strobe rising again before the end.

The bench also reaches the two frame-length corners: truncated frames and overlong frames with extra serial edges. Random frames mix these cases. Each result is compared against a model that tracks the input register, the bit count and the strobe level.

// File: rtl/sdac_pkg.sv
// Shared types for the serial converter receiver.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package sdac_pkg;

    // Receive state of the frame shifter
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,   // no frame open
        RX_BUSY = 2'd1,   // frame open, fewer than a full word captured
        RX_FULL = 2'd2    // full word captured, frame sync still low
    } rx_state_t;

endpackage

// File: rtl/sdac_sync.sv
// Multi-stage synchronizer with falling-edge detection on the synchronized level.
// Assumes: inputs are asynchronous levels that stay stable for several clk cycles.
module sdac_sync #(
    parameter int             WIDTH   = 4,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] stg [STAGES];
    logic [WIDTH-1:0] prev;

    // First stage: capture the raw asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= async_in;
    end

    // Remaining stages: chain of resolution flops
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
        end
    end

    // Delayed copy of the synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= stg[STAGES-1];
    end

    assign level = stg[STAGES-1];
    assign fall  = prev & ~stg[STAGES-1];

endmodule

// File: rtl/sdac_shifter.sv
// Frame receiver: opens a frame on a sync falling edge, then shifts one bit per
// serial clock falling edge until a full word is held. Later edges are dropped.
// A sync release before the word is full abandons the frame.
// Assumes: edge strobes are one clk cycle wide and come from sdac_sync.
module sdac_shifter
    import sdac_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_fall,
    input  logic                  fs_fall,
    input  logic                  fs_lvl,
    input  logic                  data_lvl,
    output logic [FRAME_BITS-1:0] in_reg,
    output logic [CNT_W-1:0]      bit_cnt,
    output logic                  in_prog,
    output logic                  cap_last,
    output logic [FRAME_BITS-1:0] next_word,
    output logic                  frame_done
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

    rx_state_t state;
    logic      shift_en;

    // Decode whether this cycle takes a bit into the word
    always_comb begin
        shift_en = (state == RX_BUSY) && sclk_fall && !fs_fall && !fs_lvl;
    end

    assign in_prog   = (state == RX_BUSY);
    assign next_word = {in_reg[FRAME_BITS-2:0], data_lvl};
    assign cap_last  = shift_en && (bit_cnt == LAST_IDX);

    // Frame state, bit count and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            bit_cnt    <= '0;
            frame_done <= 1'b0;
        end else if (fs_fall) begin
            state      <= RX_BUSY;
            bit_cnt    <= '0;
            frame_done <= 1'b0;
        end else begin
            case (state)
                RX_BUSY: begin
                    if (fs_lvl) begin
                        state <= RX_IDLE;
                    end else if (shift_en) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_IDX) begin
                            state      <= RX_FULL;
                            frame_done <= 1'b1;
                        end
                    end
                end
                RX_FULL: begin
                    if (fs_lvl) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // Input register: shifts only on accepted bits
    always_ff @(posedge clk) begin
        if (!rst_n)        in_reg <= '0;
        else if (shift_en) in_reg <= next_word;
    end

endmodule

// File: rtl/sdac_loader.sv
// Output register with load arbitration. A full word with the strobe low loads the
// new code. A strobe falling edge outside a frame loads the held code. A strobe
// edge inside a frame is dropped.
// Assumes: strobe level and edge come from sdac_sync; cap_last is one cycle wide.
module sdac_loader #(
    parameter int CODE_BITS = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_fall,
    input  logic                 ld_lvl,
    input  logic                 in_prog,
    input  logic                 cap_last,
    input  logic [CODE_BITS-1:0] new_code,
    input  logic [CODE_BITS-1:0] held_code,
    output logic [CODE_BITS-1:0] code_out,
    output logic                 update_pulse
);

    // Arbitrate between the end-of-frame load and the strobe-edge load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out     <= '0;
            update_pulse <= 1'b0;
        end else if (cap_last && !ld_lvl) begin
            code_out     <= new_code;
            update_pulse <= 1'b1;
        end else if (ld_fall && !in_prog) begin
            code_out     <= held_code;
            update_pulse <= 1'b1;
        end else begin
            update_pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/dac_serial_port.sv
// Top of the serial converter receiver: synchronizes the four asynchronous lines,
// receives 16-bit frames and arbitrates loads of the 14-bit output register.
// Assumes: the serial clock runs at no more than a quarter of clk.
module dac_serial_port #(
    parameter int FRAME_BITS  = 16,
    parameter int CODE_BITS   = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_in,
    input  logic                 fsync_n_in,
    input  logic                 sdata_in,
    input  logic                 load_n_in,
    output logic [CODE_BITS-1:0] code_out,
    output logic                 update_pulse,
    output logic                 frame_done
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    logic [3:0]            lvl;
    logic [3:0]            edg;
    logic                  sclk_fall, fs_fall, ld_fall;
    logic                  fs_lvl, ld_lvl, data_lvl;
    logic                  unused_data_fall;
    logic [FRAME_BITS-1:0] in_reg;
    logic [FRAME_BITS-1:0] next_word;
    logic [CNT_W-1:0]      bit_cnt;
    logic                  in_prog;
    logic                  cap_last;

    // Bit order: {sclk, fsync, load, data}; idle levels 1,1,1,0
    sdac_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1110)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({sclk_in, fsync_n_in, load_n_in, sdata_in}),
        .level   (lvl),
        .fall    (edg)
    );

    assign sclk_fall        = edg[3];
    assign fs_fall          = edg[2];
    assign ld_fall          = edg[1];
    assign unused_data_fall = edg[0];
    assign fs_lvl           = lvl[2];
    assign ld_lvl           = lvl[1];
    assign data_lvl         = lvl[0];

    sdac_shifter #(
        .FRAME_BITS(FRAME_BITS),
        .CNT_W     (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_fall (sclk_fall),
        .fs_fall   (fs_fall),
        .fs_lvl    (fs_lvl),
        .data_lvl  (data_lvl),
        .in_reg    (in_reg),
        .bit_cnt   (bit_cnt),
        .in_prog   (in_prog),
        .cap_last  (cap_last),
        .next_word (next_word),
        .frame_done(frame_done)
    );

    sdac_loader #(
        .CODE_BITS(CODE_BITS)
    ) u_load (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_fall     (ld_fall),
        .ld_lvl      (ld_lvl),
        .in_prog     (in_prog),
        .cap_last    (cap_last),
        .new_code    (next_word[CODE_BITS-1:0]),
        .held_code   (in_reg[CODE_BITS-1:0]),
        .code_out    (code_out),
        .update_pulse(update_pulse)
    );

endmodule

// File: rtl/sdac_checker.sv
// Property checker for dac_serial_port, attached by bind.
// Assumes: connected to the top-level nets named in the bind below.
module sdac_checker #(
    parameter int FRAME_BITS = 16,
    parameter int CODE_BITS  = 14,
    parameter int CNT_W      = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [CODE_BITS-1:0]  code_out,
    input logic                  update_pulse,
    input logic                  frame_done,
    input logic                  ld_lvl,
    input logic [CNT_W-1:0]      bit_cnt,
    input logic [FRAME_BITS-1:0] in_reg
);

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_out) |-> update_pulse);

    // R12
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_pulse |=> !update_pulse);

    // R7
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bit_cnt) <= FRAME_BITS);

    // R7
    word_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && $past(frame_done)) |-> $stable(in_reg));

    // R5
    strobe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_pulse |-> !$past(ld_lvl));

endmodule

bind dac_serial_port sdac_checker #(
    .FRAME_BITS(FRAME_BITS),
    .CODE_BITS (CODE_BITS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .code_out    (code_out),
    .update_pulse(update_pulse),
    .frame_done  (frame_done),
    .ld_lvl      (ld_lvl),
    .bit_cnt     (bit_cnt),
    .in_reg      (in_reg)
);

// File: tb/tb_dac_serial_port.sv
module tb_dac_serial_port;

    localparam int D = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b1;
    logic        fsync_n_in = 1'b1;
    logic        sdata_in = 1'b0;
    logic        load_n_in = 1'b1;
    logic [13:0] code_out;
    logic        update_pulse;
    logic        frame_done;

    int total = 0;
    int bad = 0;
    int pulse_cnt = 0;
    int width_bad = 0;
    logic prev_pulse = 1'b0;

    // Reference model state
    logic [15:0] ireg_m = '0;
    logic [13:0] code_m = '0;
    int          cnt_m = 0;
    bit          act_m = 0;
    bit          done_m = 0;
    bit          ld_m = 1;
    int          exp_pulses = 0;

    always #4 clk = ~clk;

    dac_serial_port dut (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .fsync_n_in(fsync_n_in),
        .sdata_in(sdata_in), .load_n_in(load_n_in), .code_out(code_out),
        .update_pulse(update_pulse), .frame_done(frame_done)
    );

    // Count output update pulses and flag any wider than one cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (update_pulse) pulse_cnt++;
            if (update_pulse && prev_pulse) width_bad++;
        end
        prev_pulse = update_pulse;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fs_low();
        @(negedge clk); fsync_n_in = 1'b0;
        act_m = 1; cnt_m = 0; done_m = 0;
        wait_clk(D);
    endtask

    task automatic fs_high();
        @(negedge clk); fsync_n_in = 1'b1;
        act_m = 0;
        wait_clk(D);
    endtask

    task automatic ld_low();
        @(negedge clk); load_n_in = 1'b0;
        if (ld_m) begin
            ld_m = 0;
            if (!(act_m && cnt_m < 16)) begin
                code_m = ireg_m[13:0];
                exp_pulses++;
            end
        end
        wait_clk(D);
    endtask

    task automatic ld_high();
        @(negedge clk); load_n_in = 1'b1;
        ld_m = 1;
        wait_clk(D);
    endtask

    task automatic sclk_bit(input logic b);
        @(negedge clk); sdata_in = b;
        wait_clk(D);
        sclk_in = 1'b0;
        if (act_m && cnt_m < 16) begin
            ireg_m = {ireg_m[14:0], b};
            cnt_m++;
            if (cnt_m == 16) begin
                done_m = 1;
                if (!ld_m) begin
                    code_m = ireg_m[13:0];
                    exp_pulses++;
                end
            end
        end
        wait_clk(D);
        sclk_in = 1'b1;
        wait_clk(D);
    endtask

    // One frame: nbits bits of word (MSB first), extra trailing edges, strobe events at bit indices
    task automatic run_frame(input logic [15:0] word, input int nbits, input int extra,
                             input int fall_at, input int rise_at);
        fs_low();
        for (int i = 0; i < nbits; i++) begin
            if (i == fall_at) ld_low();
            if (i == rise_at) ld_high();
            sclk_bit(word[15-i]);
        end
        for (int k = 0; k < extra; k++) sclk_bit(1'($urandom_range(0, 1)));
        fs_high();
    endtask

    task automatic chk_all(input string req);
        chk({req, " code"}, int'(code_out), int'(code_m));
        chk({req, " pulses"}, pulse_cnt, exp_pulses);
        chk({req, " done"}, int'(frame_done), int'(done_m));
    endtask

    // Watchdog: a hung run is a failure
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        chk("R1 code", int'(code_out), 0);
        chk("R1 pulse", int'(update_pulse), 0);
        chk("R1 done", int'(frame_done), 0);

        // R8: full frame with strobe high changes nothing at the output
        run_frame(16'hEA5B, 16, 0, -1, -1);
        chk("R8 code held", int'(code_out), 0);
        chk("R11 done after frame", int'(frame_done), 1);
        // R3 + R2: strobe edge outside a frame; first two bits dropped
        ld_low(); ld_high();
        chk("R2 code", int'(code_out), 14'h2A5B);
        chk_all("R3");

        // R4: strobe held low before and through the frame
        ld_low();
        run_frame(16'h1234, 16, 0, -1, -1);
        chk("R4 code", int'(code_out), 14'h1234);
        chk_all("R4");
        ld_high();

        // R5: strobe falls mid-frame, stays low
        run_frame(16'h3ABC, 16, 0, 7, -1);
        chk("R5 code", int'(code_out), 14'h3ABC);
        chk_all("R5");
        ld_high();

        // R6: strobe falls and rises mid-frame
        run_frame(16'h0F0F, 16, 0, 4, 10);
        chk("R6 code", int'(code_out), 14'h3ABC);
        chk_all("R6");

        // R7: extra edges ignored, then strobe copies the 16 captured bits
        run_frame(16'h5555, 16, 3, -1, -1);
        ld_low(); ld_high();
        chk("R7 code", int'(code_out), 14'h1555);
        chk_all("R7");

        // R9: abandoned frame with strobe low yields no update
        ld_low();
        run_frame(16'hFFFF, 9, 0, -1, -1);
        chk("R9 code", int'(code_out), 14'h1555);
        chk_all("R9");
        // R10: next full frame is captured from bit zero
        run_frame(16'h2468, 16, 0, -1, -1);
        chk("R10 code", int'(code_out), 14'h2468);
        chk_all("R10");
        ld_high();
        // R11: next sync falling edge clears the flag
        fs_low();
        chk("R11 cleared", int'(frame_done), 0);
        fs_high();

        // Random mix of frame shapes and strobe positions
        for (int n = 0; n < 150; n++) begin
            logic [15:0] w;
            int mode, fa, ra, nb, ex;
            w    = 16'($urandom);
            mode = $urandom_range(0, 4);
            nb   = ($urandom_range(0, 5) == 0) ? $urandom_range(1, 15) : 16;
            ex   = $urandom_range(0, 3);
            fa   = -1; ra = -1;
            if (mode == 1) ld_low();
            if (mode == 2) fa = $urandom_range(0, 15);
            if (mode == 3) begin fa = $urandom_range(0, 7); ra = $urandom_range(8, 15); end
            run_frame(w, nb, ex, fa, ra);
            if (mode == 0) begin ld_low(); ld_high(); end
            chk_all("R2 R4 R5 R6 R7 R9 random");
            if (!ld_m) ld_high();
        end

        // R12: no pulse wider than one cycle
        chk("R12 width", width_bad, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule